// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer with Arbitration Check

This block is the part of an I2C master that issues a Repeated Start on a bus the master already owns. It controls the open-drain SDA and SCL wires through two drive-low enables and watches both wires through a two-stage synchronizer. A reloadable down-counter times each of the three phases of the sequence. The length of each phase comes from a reload input.

A one-cycle request starts the sequence. The steps are:

1. SDA is released while SCL is still held low.
2. SCL is released. Once the block sees SCL rise, it checks that SDA is still high.
3. Both wires are left high for a second timed window.
4. SDA is pulled low for a third window.
5. SCL is pulled low. The Repeated Start is now complete.

The block checks for another master winning arbitration at two points. If SDA is low when SCL rises, or if SCL falls during the second window while SDA is still high, the block raises a sticky collision flag, releases both wires and returns to idle. A clean sequence raises a sticky completion flag, and the block then holds both wires low. A clear input drops both flags.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset, neither wire is driven low, busy_o is 0, and both flags are 0.
- R2: When a request is accepted, SDA is released and SCL is held low for exactly N cycles. N is reload_i, except that a reload_i of 0 gives N = 1. SCL is released after that.
- R3: If synchronized SDA is low in the cycle where synchronized SCL is first seen rising, coll_flag_o is set.
- R4: SDA falling during the second window, with SCL still high, is not a collision. The sequence goes on to completion.
- R5: If synchronized SCL falls during the second window while synchronized SDA is high, coll_flag_o is set.
- R6: With no other bus activity, busy_o stays high for exactly 3*N+3 cycles. The block then sets done_flag_o and drives both SDA and SCL low while idle.
- R7: On a collision, both drive enables drop in the same cycle that coll_flag_o rises. They stay low while the block is idle afterwards.
- R8: Both flags stay set until clr_i is pulsed. clr_i clears them on the next clock edge.
- R9: A start_i pulse that arrives while busy_o is high is ignored. It neither lengthens the sequence nor starts a new one afterwards.
- R10: A reload_i of 0 behaves as a one-cycle phase. The whole clean sequence then takes 6 cycles.
- R11: When the third window ends, SCL is driven low and done_flag_o is set, even if SCL is already being pulled low by another device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request for a Repeated Start |
| clr_i | input | 1 | Clears both sticky flags |
| reload_i | input | CNT_W | Length of each phase in clock cycles (0 is treated as 1) |
| sda_i | input | 1 | Level of the SDA wire |
| scl_i | input | 1 | Level of the SCL wire |
| sda_drive_o | output | 1 | 1 pulls SDA low |
| scl_drive_o | output | 1 | 1 pulls SCL low |
| busy_o | output | 1 | A sequence is in progress |
| done_flag_o | output | 1 | Sticky flag: the Repeated Start completed |
| coll_flag_o | output | 1 | Sticky flag: a bus collision was detected |

## Verification
The bench models the wired-AND bus. It checks the sequence in three settings:

- **Quiet bus, several phase lengths, including zero.** The busy length and the SCL-low phase length confirm the counter reload and the synchronizer latency.
- **SDA held low by another device from the start.** This must be caught at the SCL rise.
- **SCL pulled low in the middle of the second window.** This must also be reported as a collision.

Two further patterns must not be reported as collisions: SDA pulled low briefly during the second window, and SCL pulled low during the third window. Keeping these apart from the two real collisions shows that each check is active only in its own phase.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCL_LOW,   // first window: SDA released, SCL held low
    ST_WAIT_HI,   // SCL released, waiting to see it rise
    ST_BOTH_HI,   // second window: both released
    ST_SDA_LOW    // third window: SDA low, SCL released
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/i2c_rs_brg.sv
module i2c_rs_brg #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  // counts reload-1 .. 0, so a phase lasts max(reload,1) cycles
  assign load_val = (reload_i == '0) ? '0 : reload_i - ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
  import i2c_rs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             sda_i,
  input  logic             scl_i,
  output logic             sda_drive_o,
  output logic             scl_drive_o,
  output logic             busy_o,
  output logic             done_flag_o,
  output logic             coll_flag_o
);
  localparam int NLINES = 2;

  rs_state_e        state_q, state_d;
  logic [NLINES-1:0] lines_s;
  logic              sda_s, scl_s, scl_prev_q;
  logic              scl_rise, scl_fall;
  logic              load, expired;
  logic              hold_q, hold_d;
  logic              set_done, set_coll;
  logic              done_q, coll_q;

  i2c_rs_sync #(.W(NLINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );
  assign sda_s = lines_s[0];
  assign scl_s = lines_s[1];

  i2c_rs_brg #(.CNT_W(CNT_W)) u_brg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .reload_i (reload_i),
    .expired_o(expired)
  );

  assign scl_rise = scl_s & ~scl_prev_q;
  assign scl_fall = ~scl_s & scl_prev_q;

  always_comb begin
    state_d  = state_q;
    hold_d   = hold_q;
    load     = 1'b0;
    set_done = 1'b0;
    set_coll = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SCL_LOW;
        load    = 1'b1;
      end
      ST_SCL_LOW: if (expired) state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (scl_rise) begin
        if (!sda_s) begin  // other master sends 0
          set_coll = 1'b1;
          hold_d   = 1'b0;
          state_d  = ST_IDLE;
        end else begin
          load    = 1'b1;
          state_d = ST_BOTH_HI;
        end
      end
      ST_BOTH_HI: begin
        if (scl_fall && sda_s) begin  // other master sends 1
          set_coll = 1'b1;
          hold_d   = 1'b0;
          state_d  = ST_IDLE;
        end else if (expired) begin
          load    = 1'b1;
          state_d = ST_SDA_LOW;
        end
      end
      ST_SDA_LOW: if (expired) begin
        set_done = 1'b1;
        hold_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      hold_q     <= 1'b0;
      scl_prev_q <= 1'b1;
      done_q     <= 1'b0;
      coll_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      hold_q     <= hold_d;
      scl_prev_q <= scl_s;
      // set wins over clear
      done_q     <= set_done | (done_q & ~clr_i);
      coll_q     <= set_coll | (coll_q & ~clr_i);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:    begin sda_drive_o = hold_q; scl_drive_o = hold_q; end
      ST_SCL_LOW: begin sda_drive_o = 1'b0;   scl_drive_o = 1'b1;   end
      ST_SDA_LOW: begin sda_drive_o = 1'b1;   scl_drive_o = 1'b0;   end
      default:    begin sda_drive_o = 1'b0;   scl_drive_o = 1'b0;   end
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_flag_o = done_q;
  assign coll_flag_o = coll_q;
endmodule

// File: rtl/i2c_rstart_gen_chk.sv
module i2c_rstart_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic start_i,
  input logic sda_drive_o,
  input logic scl_drive_o,
  input logic busy_o,
  input logic done_flag_o,
  input logic coll_flag_o
);
  assert_first_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (scl_drive_o && !sda_drive_o));

  assert_done_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> (scl_drive_o && sda_drive_o && !busy_o));

  assert_coll_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_flag_o) |-> (!scl_drive_o && !sda_drive_o && !busy_o));

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_flag_o && !clr_i) |=> done_flag_o);

  assert_coll_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_flag_o && !clr_i) |=> coll_flag_o);

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind i2c_rstart_gen i2c_rstart_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .start_i    (start_i),
  .sda_drive_o(sda_drive_o),
  .scl_drive_o(scl_drive_o),
  .busy_o     (busy_o),
  .done_flag_o(done_flag_o),
  .coll_flag_o(coll_flag_o)
);

// File: tb/i2c_rstart_gen_test.sv
module i2c_rstart_gen_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic clr_i = 1'b0;
  logic [CNT_W-1:0] reload_i = '0;
  logic ext_sda_low = 1'b0;
  logic ext_scl_low = 1'b0;
  logic sda_drive_o, scl_drive_o, busy_o, done_flag_o, coll_flag_o;
  logic sda_bus, scl_bus;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  assign sda_bus = !(sda_drive_o || ext_sda_low);
  assign scl_bus = !(scl_drive_o || ext_scl_low);

  i2c_rstart_gen #(.CNT_W(CNT_W)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .clr_i      (clr_i),
    .reload_i   (reload_i),
    .sda_i      (sda_bus),
    .scl_i      (scl_bus),
    .sda_drive_o(sda_drive_o),
    .scl_drive_o(scl_drive_o),
    .busy_o     (busy_o),
    .done_flag_o(done_flag_o),
    .coll_flag_o(coll_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk) clr_i = 1'b1;
    @(negedge clk) clr_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy_o; i++) @(negedge clk);
  endtask

  // wait until SCL has been released (second phase entered)
  task automatic wait_released();
    for (int i = 0; i < 1000 && !(busy_o && !scl_drive_o && !sda_drive_o); i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!sda_drive_o && !scl_drive_o, "R1 drives", {sda_drive_o, scl_drive_o}, 0);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!done_flag_o && !coll_flag_o, "R1 flags", {done_flag_o, coll_flag_o}, 0);
  endtask

  task automatic t_clean(input int rl, input bit mid_start);
    int n = 0;
    int p1 = 0;
    int eff;
    eff = (rl == 0) ? 1 : rl;
    reload_i = CNT_W'(rl);
    clear_flags();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (busy_o && n < 1000) begin
      n++;
      if (scl_drive_o && !sda_drive_o) p1++;
      start_i = mid_start && (n == 3);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(p1 == eff, "R2 scl-low phase length", p1, eff);
    chk(n == 3*eff + 3, mid_start ? "R9 length with ignored start" :
        (rl == 0 ? "R10 zero reload length" : "R6 busy length"), n, 3*eff + 3);
    chk(done_flag_o && !coll_flag_o, "R6 done flag", {done_flag_o, coll_flag_o}, 2);
    chk(sda_drive_o && scl_drive_o, "R6 hold both low", {sda_drive_o, scl_drive_o}, 3);
    if (mid_start) begin
      repeat (4) @(negedge clk);
      chk(!busy_o, "R9 no restart after ignored start", busy_o, 0);
    end
  endtask

  task automatic t_coll_sda();
    reload_i = 8'd4;
    clear_flags();
    ext_sda_low = 1'b1;
    pulse_start();
    wait_idle();
    chk(coll_flag_o && !done_flag_o, "R3 collision on sda low", {coll_flag_o, done_flag_o}, 2);
    chk(!sda_drive_o && !scl_drive_o, "R7 released", {sda_drive_o, scl_drive_o}, 0);
    ext_sda_low = 1'b0;
    repeat (5) @(negedge clk);
    chk(!sda_drive_o && !scl_drive_o, "R7 stays released", {sda_drive_o, scl_drive_o}, 0);
    chk(coll_flag_o, "R8 flag sticky", coll_flag_o, 1);
    clear_flags();
    chk(!coll_flag_o, "R8 clear", coll_flag_o, 0);
  endtask

  task automatic t_coll_scl();
    reload_i = 8'd10;
    clear_flags();
    pulse_start();
    wait_released();
    repeat (5) @(negedge clk);
    ext_scl_low = 1'b1;
    wait_idle();
    chk(coll_flag_o && !done_flag_o, "R5 collision on scl fall", {coll_flag_o, done_flag_o}, 2);
    chk(!sda_drive_o && !scl_drive_o, "R7 released after scl collision", {sda_drive_o, scl_drive_o}, 0);
    @(negedge clk) ext_scl_low = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_sda_fall_ok();
    reload_i = 8'd10;
    clear_flags();
    pulse_start();
    wait_released();
    repeat (5) @(negedge clk);
    ext_sda_low = 1'b1;
    repeat (4) @(negedge clk);
    ext_sda_low = 1'b0;
    wait_idle();
    chk(done_flag_o && !coll_flag_o, "R4 sda fall tolerated", {done_flag_o, coll_flag_o}, 2);
  endtask

  task automatic t_scl_third();
    reload_i = 8'd10;
    clear_flags();
    pulse_start();
    wait_released();
    repeat (15) @(negedge clk);
    chk(sda_drive_o && !scl_drive_o, "R11 in third window", {sda_drive_o, scl_drive_o}, 2);
    ext_scl_low = 1'b1;
    wait_idle();
    chk(done_flag_o && !coll_flag_o, "R11 done despite scl low", {done_flag_o, coll_flag_o}, 2);
    chk(scl_drive_o, "R11 scl driven low", scl_drive_o, 1);
    ext_scl_low = 1'b0;
    clear_flags();
    chk(!done_flag_o, "R8 clear done", done_flag_o, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean(5, 1'b0);
    t_clean(0, 1'b0);
    t_clean(7, 1'b1);
    t_coll_sda();
    t_clean(1, 1'b0);
    t_coll_scl();
    t_sda_fall_ok();
    t_scl_third();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule